// File: doc/BRIEF.md
# Selectable-Mode Pulse-Swallow Feedback Divider

This block sits in the feedback path of a frequency synthesizer. Each edge of the local-oscillator signal arrives as a one-cycle `lo_tick` strobe in the system clock domain. The block divides the stream of strobes by a programmable ratio and emits one single-cycle `fb_pulse` per divided period. That pulse is what a phase comparator compares against the reference.

A 16-bit divisor word and two mode inputs choose how the division is done. In the prescaled and swallow modes, the word splits into a 4-bit swallow count S and a 12-bit main count M. The divider then runs a 16/17 dual-modulus stage for M cycles: S of those cycles use the 17 modulus and the rest use 16, so the ratio is 16·M + S. In prescaled mode a divide-by-two stage goes in front, which doubles the ratio. In direct mode only the upper 12 bits of the word count, used as a plain modulus.

A new word or mode is taken only at the end of the period in progress, so the output never shows a short or stretched period. The `inhibit` input halts the divider and clears all counting state.

Top module: `pswd_divider`

## Requirements
- R1: While `rst_n` is low (sampled on the clock), `fb_pulse` stays 0 and incoming ticks are not counted. After release, the mode and divisor present on the inputs are loaded in the first cycle. Ticks are counted from the cycle after that.
- R2: With `hi_band`=1 (prescaled mode), exactly one `fb_pulse` occurs per 2·W ticks, where W is the whole 16-bit word (legal W: 272..65535). Example: W=0x07DE gives 4028 ticks.
- R3: With `hi_band`=0 and `swallow_sel`=1 (swallow mode), one `fb_pulse` occurs per W ticks, with W = 16·`div_word[15:4]` + `div_word[3:0]` (legal W: 272..65535). Example: W=0x1158 gives 4440 ticks.
- R4: With `hi_band`=0 and `swallow_sel`=0 (direct mode), one `fb_pulse` occurs per D ticks, with D = `div_word[15:4]` (legal D: 4..4095). Bits `div_word[3:0]` have no effect. Example: D=0x0A2 gives 162 ticks.
- R5: When `hi_band`=1, the value of `swallow_sel` has no effect on the ratio.
- R6: A change of `div_word`, `hi_band` or `swallow_sel` during a period does not alter that period. The values present at the clock edge that counts the period's last tick apply from the next period on.
- R7: While `inhibit` is high, `fb_pulse` is 0. After `inhibit` falls, the inputs are reloaded in the first cycle and counting restarts from zero, so the first pulse comes after a full period.
- R8: `fb_pulse` is high for exactly one clock cycle. It appears in the cycle after the edge that counted the period's last tick.
- R9: Ticks arriving while `inhibit` is high are not counted toward any period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inhibit | input | 1 | Stops the divider and clears its counting state |
| lo_tick | input | 1 | One-cycle strobe per local-oscillator edge |
| hi_band | input | 1 | 1 selects the prescaled mode |
| swallow_sel | input | 1 | With `hi_band`=0: 1 swallow mode, 0 direct mode |
| div_word | input | 16 | Divisor word: [15:4] main count, [3:0] swallow count |
| fb_pulse | output | 1 | One-cycle pulse per divided period |

## Verification
The assertions assume that the divisor word is always legal for the selected mode: at least 272 in the two swallow modes and a 12-bit field of at least 4 in direct mode. Under that assumption the main count exceeds the swallow count, and the period is never shorter than the pulse itself. The stimulus draws only from these legal ranges, both for the random periods and for the directed boundary values 272, 511, 4 and 4095. It also changes the inputs only at the half-way tick of a period or while the block is inhibited.

// File: rtl/pswd_pkg.sv
// Shared types for the pulse-swallow feedback divider.
// Assumes callers pass the raw mode inputs; the decoding gives hi_band priority.
package pswd_pkg;

    typedef enum logic [1:0] {
        DM_PRESCALED = 2'd0,
        DM_SWALLOW   = 2'd1,
        DM_DIRECT    = 2'd2
    } div_mode_e;

    // Map the two mode inputs onto a division mode.
    function automatic div_mode_e pick_mode(input logic hb, input logic sw);
        if (hb)
            return DM_PRESCALED;
        else if (sw)
            return DM_SWALLOW;
        else
            return DM_DIRECT;
    endfunction

endpackage

// File: rtl/pswd_prescaler.sv
// Divide-by-two stage in front of the swallow divider.
// When enabled it passes every second input tick; when disabled it passes all ticks.
// Assumes clr is raised whenever counting restarts, so the phase starts at zero.
module pswd_prescaler (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic tick_in,
    output logic tick_out
);

    logic phase;

    // Toggle the phase on every accepted tick while the stage is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            phase <= 1'b0;
        else if (en && tick_in)
            phase <= ~phase;
    end

    // Pass the second tick of each pair, or every tick when bypassed.
    always_comb begin
        tick_out = en ? (tick_in & phase) : tick_in;
    end

    // R2
    halving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick_out) |=> !(en && tick_out));

endmodule

// File: rtl/pswd_swallow_core.sv
// Dual-modulus swallow divider: a (2^SWL_W)/(2^SWL_W+1) modulus stage run for
// main_cnt cycles, with the larger modulus used for the first swl_cnt cycles.
// Ratio = main_cnt * 2^SWL_W + swl_cnt. Assumes main_cnt > swl_cnt while ticking.
// Counters wrap to zero at period end, so a config change there is seen cleanly.
module pswd_swallow_core #(
    parameter int SWL_W  = 4,
    parameter int MAIN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic [SWL_W-1:0]  swl_cnt,
    input  logic [MAIN_W-1:0] main_cnt,
    output logic              wrap
);

    localparam int MOD_BASE = 1 << SWL_W;

    logic [SWL_W:0]    prs_cnt;
    logic [MAIN_W-1:0] mod_idx;
    logic              extra;
    logic [SWL_W:0]    prs_last;
    logic              prs_term;
    logic              last_cycle;

    // Pick the modulus of the current cycle and detect its end.
    always_comb begin
        extra      = mod_idx < MAIN_W'(swl_cnt);
        prs_last   = extra ? (SWL_W+1)'(MOD_BASE) : (SWL_W+1)'(MOD_BASE - 1);
        prs_term   = tick && (prs_cnt == prs_last);
        last_cycle = (mod_idx == main_cnt - MAIN_W'(1));
        wrap       = prs_term && last_cycle;
    end

    // Modulus stage counter: counts ticks within one 16- or 17-tick cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            prs_cnt <= '0;
        else if (prs_term)
            prs_cnt <= '0;
        else if (tick)
            prs_cnt <= prs_cnt + 1'b1;
    end

    // Main counter: counts completed modulus cycles within the period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            mod_idx <= '0;
        else if (wrap)
            mod_idx <= '0;
        else if (prs_term)
            mod_idx <= mod_idx + 1'b1;
    end

    // R3
    prs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prs_cnt <= (SWL_W+1)'(MOD_BASE));

    // R3
    main_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (mod_idx < main_cnt));

endmodule

// File: rtl/pswd_direct_ctr.sv
// Plain modulo-limit tick counter for the direct division mode.
// Assumes limit >= 2 while ticks arrive; wraps to zero on the limit-th tick.
module pswd_direct_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         wrap
);

    logic [W-1:0] cnt;

    // Flag the tick that completes the period.
    always_comb begin
        wrap = tick && (cnt == limit - W'(1));
    end

    // Count ticks, restarting at zero after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // R4
    direct_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (cnt < limit));

endmodule

// File: rtl/pswd_divider.sv
// Top of the selectable-mode feedback divider.
// Latches divisor and mode at period boundaries, routes ticks to the
// prescaled/swallow path or the direct counter, and registers the output pulse.
// Assumes a legal divisor for the selected mode and lo_tick one cycle wide.
module pswd_divider #(
    parameter int DIV_W = 16,
    parameter int SWL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inhibit,
    input  logic             lo_tick,
    input  logic             hi_band,
    input  logic             swallow_sel,
    input  logic [DIV_W-1:0] div_word,
    output logic             fb_pulse
);

    import pswd_pkg::*;

    localparam int MAIN_W = DIV_W - SWL_W;

    logic             armed;
    logic [DIV_W-1:0] act_word;
    div_mode_e        act_mode;
    logic             clr;
    logic             eff_tick;
    logic             pre_tick;
    logic             swl_tick;
    logic             dir_tick;
    logic             swl_wrap;
    logic             dir_wrap;
    logic             period_end;
    logic             load;

    // Gate ticks and decide when the active configuration is refreshed.
    always_comb begin
        clr        = !armed || inhibit;
        eff_tick   = lo_tick && armed && !inhibit;
        swl_tick   = (act_mode != DM_DIRECT) ? pre_tick : 1'b0;
        dir_tick   = (act_mode == DM_DIRECT) ? eff_tick : 1'b0;
        period_end = (act_mode == DM_DIRECT) ? dir_wrap : swl_wrap;
        load       = !inhibit && (!armed || period_end);
    end

    // Arm after reset or inhibit, and take new settings only at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            act_word <= '0;
            act_mode <= DM_DIRECT;
        end else if (inhibit) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (load) begin
                act_word <= div_word;
                act_mode <= pick_mode(hi_band, swallow_sel);
            end
        end
    end

    pswd_prescaler u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .en       (act_mode == DM_PRESCALED),
        .tick_in  (eff_tick),
        .tick_out (pre_tick)
    );

    pswd_swallow_core #(
        .SWL_W  (SWL_W),
        .MAIN_W (MAIN_W)
    ) u_swl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .tick     (swl_tick),
        .swl_cnt  (act_word[SWL_W-1:0]),
        .main_cnt (act_word[DIV_W-1:SWL_W]),
        .wrap     (swl_wrap)
    );

    pswd_direct_ctr #(
        .W (MAIN_W)
    ) u_dir (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .tick  (dir_tick),
        .limit (act_word[DIV_W-1:SWL_W]),
        .wrap  (dir_wrap)
    );

    // Register the period-end strobe as the feedback pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || inhibit)
            fb_pulse <= 1'b0;
        else
            fb_pulse <= period_end;
    end

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    // R7
    inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> !fb_pulse);

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !inhibit && !period_end) |=> ($stable(act_word) && $stable(act_mode)));

endmodule

// File: tb/pswd_divider_test.sv
// Self-checking bench for the feedback divider: directed corners plus
// seeded random periods, expected ratios computed from the requirements.
module pswd_divider_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inhibit = 1'b0;
    logic        lo_tick = 1'b0;
    logic        hi_band = 1'b0;
    logic        swallow_sel = 1'b0;
    logic [15:0] div_word = 16'h0;
    logic        fb_pulse;

    int n_checks = 0;
    int n_err = 0;
    int stray = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pswd_divider uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .inhibit     (inhibit),
        .lo_tick     (lo_tick),
        .hi_band     (hi_band),
        .swallow_sel (swallow_sel),
        .div_word    (div_word),
        .fb_pulse    (fb_pulse)
    );

    // Expected ticks per period from the mode rules.
    function automatic int exp_ratio(bit hb, bit sw, logic [15:0] w);
        if (hb) return 2 * int'(w);
        if (sw) return int'(w);
        return int'(w[15:4]);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive_cfg(bit hb, bit sw, logic [15:0] w);
        hi_band = hb;
        swallow_sel = sw;
        div_word = w;
    endtask

    function automatic int pick_gap();
        if ($urandom % 8 == 0) return int'($urandom % 3);
        return 0;
    endfunction

    // One tick with an optional idle gap; returns the pulse seen after it.
    task automatic tick_once(int gap, output bit p);
        repeat (gap) begin
            @(negedge clk);
            if (fb_pulse) stray++;
        end
        @(negedge clk);
        lo_tick = 1'b1;
        @(negedge clk);
        lo_tick = 1'b0;
        p = fb_pulse;
    endtask

    // Run one period; optionally present the next setting half way through.
    task automatic run_period(int exp_n, bit chg, bit nhb, bit nsw,
                              logic [15:0] nw, string req);
        int first = 0;
        bit p;
        stray = 0;
        for (int i = 1; i <= exp_n; i++) begin
            if (chg && i == exp_n / 2 + 1) drive_cfg(nhb, nsw, nw);
            tick_once(pick_gap(), p);
            if (p && first == 0) first = i;
        end
        check(first == exp_n && stray == 0, req, "ticks to feedback pulse", first, exp_n);
        @(negedge clk);
        // R8: pulse lasts one cycle
        check(fb_pulse == 1'b0, "R8", "pulse width", int'(fb_pulse), 0);
    endtask

    initial begin
        bit hb;
        bit sw;
        logic [15:0] w;
        bit p;
        int cur;
        void'($urandom(32'h5EED_0042));

        // R1: reset holds output low even with ticks present.
        drive_cfg(1'b1, 1'b0, 16'h07DE);
        stray = 0;
        repeat (10) begin
            @(negedge clk);
            lo_tick = ~lo_tick;
            if (fb_pulse) stray++;
        end
        lo_tick = 1'b0;
        check(stray == 0 && fb_pulse == 1'b0, "R1", "pulses during reset", stray, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 example, then R3 example, then R4 example with junk low bits.
        run_period(4028, 1, 1'b0, 1'b1, 16'h1158, "R2 R1");
        run_period(4440, 1, 1'b0, 1'b0, 16'h0A27, "R3 R6");
        // R5: swallow_sel set while prescaled must not matter.
        run_period(162, 1, 1'b1, 1'b1, 16'd300, "R4 R6");
        run_period(600, 1, 1'b1, 1'b0, 16'd272, "R5");
        run_period(544, 1, 1'b0, 1'b0, 16'h004F, "R2 boundary");
        run_period(4, 1, 1'b0, 1'b1, 16'd272, "R4 minimum");
        run_period(272, 1, 1'b0, 1'b1, 16'h01FF, "R3 minimum");
        run_period(511, 1, 1'b0, 1'b0, 16'hFFF3, "R3 full swallow");
        hb = 1'b0; sw = 1'b1; w = 16'd300;
        run_period(4095, 1, hb, sw, w, "R4 maximum");
        cur = exp_ratio(hb, sw, w);

        // Random periods in legal ranges; each changes setting mid-period (R6).
        for (int k = 0; k < 12; k++) begin
            int m = int'($urandom % 3);
            bit nhb = (m == 0);
            bit nsw = (m == 1) ? 1'b1 : ((m == 0) ? 1'($urandom) : 1'b0);
            logic [15:0] nw;
            if (m == 0) nw = 16'(272 + $urandom % 128);
            else if (m == 1) nw = 16'(272 + $urandom % 256);
            else nw = 16'(((4 + $urandom % 497) << 4) | ($urandom % 16));
            run_period(cur, 1, nhb, nsw, nw, "R6 random");
            cur = exp_ratio(nhb, nsw, nw);
        end

        // R7 / R9: inhibit mid-period, ticks ignored, restart from zero.
        stray = 0;
        repeat (10) begin
            tick_once(0, p);
            if (p) stray++;
        end
        @(negedge clk);
        inhibit = 1'b1;
        repeat (30) begin
            tick_once(pick_gap(), p);
            if (p) stray++;
        end
        check(stray == 0, "R9", "pulses while inhibited", stray, 0);
        check(fb_pulse == 1'b0, "R7", "output while inhibited", int'(fb_pulse), 0);
        drive_cfg(1'b0, 1'b1, 16'd333);
        @(negedge clk);
        inhibit = 1'b0;
        @(negedge clk);
        run_period(333, 0, 1'b0, 1'b0, 16'h0, "R7 restart");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule